// File: doc/BRIEF.md
# Double-Buffered Pixel Frame Fetcher

The block streams one frame buffer, held in external memory, out as a video pixel stream. It walks the source image in raster order starting from the front-buffer base address and issues one half-word read per source pixel. Each 16-bit RGB565 pixel is widened to a 30-bit colour word and sent on a ready/valid stream. Every source pixel is sent several times in a row and every source line is fetched again for each repeated output line. A 320x240 buffer therefore fills a 640x480 output.

Software reaches the block through a small word-indexed register port. It writes the address of a second, back buffer. It then asks for an exchange by writing to the read-only front-base register, and the written data is discarded. The exchange waits until the last output pixel of the frame in flight has been accepted. While it waits, a pending bit in the status word reads 1, so software can pace its drawing to the frame rate.

Top module: `pixel_frame_fetcher`

## Requirements
- R1: After reset the front base (index 0) and back base (index 1) read 0, status bit 0 reads 0, and the first memory request is at byte address 0.
- R2: A write to index 1 sets the back base, which reads back unchanged. A write to index 0 leaves the front base unchanged and its data is not used.
- R3: A write to index 0 sets the pending bit (status bit 0). When the last output pixel of a frame is accepted while a request is pending, the front and back bases exchange and the pending bit clears in the next cycle. Further requests made while one is pending cause no extra exchange.
- R4: Index 2 reads the horizontal source size in bits 15:0 and the vertical source size in bits 31:16 (320 and 240 by default).
- R5: Index 3 reads ceil(log2(horizontal size)) in bits 31:24, ceil(log2(vertical size)) in bits 23:16, the value 2 (bytes per colour) in bits 7:4, the address-mode bit in bit 1 and the pending bit in bit 0. All other bits are 0.
- R6: In coordinate mode (mode bit 0), the byte address of source pixel (x, y) is front base + 2*((y << m) | x), where m is the width of x.
- R7: In linear mode (mode bit 1), the byte address of source pixel (x, y) is front base + 2*(y*H + x).
- R8: Output order is raster. Each source pixel is sent SCALE times in a row and each source row is fetched for SCALE output lines, which gives H*SCALE by V*SCALE pixels per frame before the scan wraps to (0,0).
- R9: The output word is {red10, green10, blue10}. Each channel copies its 5 or 6 source bits into the high bits and repeats its top bits below them, so 0xF800 becomes {3FF,000,000} and 0x8410 becomes {210,208,210}.
- R10: pixValid stays high with pixData unchanged until pixReady. pixLineEnd marks the last pixel of each output line and pixFrameEnd marks the last pixel of the frame.
- R11: memReq stays high with memAddr unchanged until memGnt.
- R12: Writes to index 2 and index 3 change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| memReq | output | 1 | Read request valid |
| memAddr | output | ADDR_W | Read byte address |
| memGnt | input | 1 | Read request accepted |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 16 | RGB565 read data |
| pixValid | output | 1 | Output pixel valid |
| pixReady | input | 1 | Output pixel accepted |
| pixData | output | 30 | Widened colour |
| pixLineEnd | output | 1 | Last pixel of an output line |
| pixFrameEnd | output | 1 | Last pixel of the frame |

## Verification
The assertions assume the memory returns exactly one response for each granted request, and only while the fetcher is waiting for it. The bench's memory model answers every granted request once, one cycle later, and never otherwise. They also assume register writes to the back base do not land in the same cycle as an exchange. Register writes in the bench land early in a frame, far from its last pixel. Grant and ready are stalled on fixed patterns so that the hold rules are exercised without breaking these assumptions.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic [1:0] {ST_FETCH, ST_WAIT, ST_SEND} fetchState_t;

  typedef struct packed {
    logic loadPix;
    logic emitPix;
  } scanStrobes_t;

  localparam logic [1:0] REG_FRONT = 2'd0;
  localparam logic [1:0] REG_BACK  = 2'd1;
  localparam logic [1:0] REG_RES   = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;
  localparam logic [3:0] COLOUR_BYTES = 4'd2;
endpackage

// File: rtl/pff_regs.sv
module pff_regs import pff_pkg::*; #(
  parameter int H_RES  = 320,
  parameter int V_RES  = 240,
  parameter bit CONSEC = 1'b0,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              frameEnd,
  output logic [31:0]       regRdata,
  output logic [ADDR_W-1:0] frontBase
);
  localparam int XW = $clog2(H_RES);
  localparam int YW = $clog2(V_RES);

  logic [ADDR_W-1:0] frontQ, backQ;
  logic pendingQ;
  logic swapReq, doSwap;

  assign swapReq = regWe && (regAddr == REG_FRONT);
  assign doSwap  = frameEnd && (pendingQ || swapReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontQ   <= '0;
      backQ    <= '0;
      pendingQ <= 1'b0;
    end else if (doSwap) begin
      frontQ   <= backQ;
      backQ    <= frontQ;
      pendingQ <= 1'b0;
    end else begin
      if (swapReq) pendingQ <= 1'b1;
      if (regWe && regAddr == REG_BACK) backQ <= regWdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      REG_FRONT: regRdata = 32'(frontQ);
      REG_BACK:  regRdata = 32'(backQ);
      REG_RES:   regRdata = {16'(V_RES), 16'(H_RES)};
      default:   regRdata = {8'(XW), 8'(YW), 8'h00, COLOUR_BYTES, 2'b00, CONSEC, pendingQ};
    endcase
  end

  assign frontBase = frontQ;

  p_pending_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !frameEnd) |=> pendingQ);
  p_swap_takes_back_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && pendingQ) |=> (frontQ == $past(backQ) && !pendingQ));
  p_front_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(frontQ));
endmodule

// File: rtl/pff_ctrl.sv
module pff_ctrl import pff_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         memGnt,
  input  logic         memRspValid,
  input  logic         pixReady,
  input  logic         copyLast,
  output logic         memReq,
  output logic         pixValid,
  output scanStrobes_t strobes
);
  fetchState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_FETCH: if (memGnt) stateD = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateD = ST_SEND;
      ST_SEND:  if (pixReady && copyLast) stateD = ST_FETCH;
      default:  stateD = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_FETCH;
    else       stateQ <= stateD;
  end

  assign memReq          = (stateQ == ST_FETCH);
  assign pixValid        = (stateQ == ST_SEND);
  assign strobes.loadPix = (stateQ == ST_WAIT) && memRspValid;
  assign strobes.emitPix = pixValid && pixReady;

  // Input assumption: a response only arrives while one is awaited (R11).
  p_rsp_expected_r11: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (stateQ == ST_WAIT));
  p_pixel_follows_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixValid) |-> $past(memRspValid));
  p_req_xor_pix_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && pixValid));
endmodule

// File: rtl/pff_scan.sv
module pff_scan import pff_pkg::*; #(
  parameter int H_RES  = 320,
  parameter int V_RES  = 240,
  parameter int SCALE  = 2,
  parameter bit CONSEC = 1'b0,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobes_t      strobes,
  input  logic [ADDR_W-1:0] frontBase,
  input  logic [15:0]       memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [29:0]       pixData,
  output logic              copyLast,
  output logic              lineLast,
  output logic              frameLast
);
  localparam int XW    = $clog2(H_RES);
  localparam int YW    = $clog2(V_RES);
  localparam int OUT_V = V_RES * SCALE;
  localparam int OYW   = $clog2(OUT_V);
  localparam int CW    = (SCALE > 1) ? $clog2(SCALE) : 1;
  localparam int OFF_W = CONSEC ? $clog2(H_RES * V_RES) : XW + YW;

  logic [XW-1:0]    srcX;
  logic [OYW-1:0]   outY;
  logic [CW-1:0]    copyCnt;
  logic [YW-1:0]    srcY;
  logic [OFF_W-1:0] offset;
  logic [15:0]      pixQ;

  assign srcY      = YW'(outY / OYW'(SCALE));
  assign copyLast  = (copyCnt == CW'(SCALE - 1));
  assign lineLast  = copyLast && (srcX == XW'(H_RES - 1));
  assign frameLast = lineLast && (outY == OYW'(OUT_V - 1));

  generate
    if (CONSEC) begin : g_linear
      assign offset = OFF_W'(srcY) * OFF_W'(H_RES) + OFF_W'(srcX);
    end else begin : g_coord
      assign offset = {srcY, srcX};
    end
  endgenerate

  assign memAddr = frontBase + ADDR_W'({offset, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcX    <= '0;
      outY    <= '0;
      copyCnt <= '0;
      pixQ    <= '0;
    end else begin
      if (strobes.loadPix) pixQ <= memRspData;
      if (strobes.emitPix) begin
        if (copyLast) begin
          copyCnt <= '0;
          if (srcX == XW'(H_RES - 1)) begin
            srcX <= '0;
            outY <= (outY == OYW'(OUT_V - 1)) ? '0 : outY + 1'b1;
          end else begin
            srcX <= srcX + 1'b1;
          end
        end else begin
          copyCnt <= copyCnt + 1'b1;
        end
      end
    end
  end

  assign pixData = {pixQ[15:11], pixQ[15:11],
                    pixQ[10:5],  pixQ[10:7],
                    pixQ[4:0],   pixQ[4:0]};

  p_wrap_after_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emitPix && frameLast) |=> (srcX == '0 && outY == '0 && copyCnt == '0));
  p_line_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emitPix && lineLast && !frameLast) |=> (outY == $past(outY) + 1'b1));
  p_pixel_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadPix |=> $stable(pixQ));
endmodule

// File: rtl/pixel_frame_fetcher.sv
module pixel_frame_fetcher import pff_pkg::*; #(
  parameter int H_RES  = 320,
  parameter int V_RES  = 240,
  parameter int SCALE  = 2,
  parameter bit CONSEC = 1'b0,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic              memRspValid,
  input  logic [15:0]       memRspData,
  output logic              pixValid,
  input  logic              pixReady,
  output logic [29:0]       pixData,
  output logic              pixLineEnd,
  output logic              pixFrameEnd
);
  scanStrobes_t      strobes;
  logic              copyLast, lineLast, frameLast, frameEnd;
  logic [ADDR_W-1:0] frontBase;

  assign frameEnd = strobes.emitPix && frameLast;

  pff_regs #(.H_RES(H_RES), .V_RES(V_RES), .CONSEC(CONSEC), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .frameEnd(frameEnd), .regRdata(regRdata), .frontBase(frontBase));

  pff_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .memGnt(memGnt), .memRspValid(memRspValid),
    .pixReady(pixReady), .copyLast(copyLast), .memReq(memReq),
    .pixValid(pixValid), .strobes(strobes));

  pff_scan #(.H_RES(H_RES), .V_RES(V_RES), .SCALE(SCALE), .CONSEC(CONSEC),
             .ADDR_W(ADDR_W)) i_scan (
    .clk(clk), .rstN(rstN), .strobes(strobes), .frontBase(frontBase),
    .memRspData(memRspData), .memAddr(memAddr), .pixData(pixData),
    .copyLast(copyLast), .lineLast(lineLast), .frameLast(frameLast));

  assign pixLineEnd  = pixValid && lineLast;
  assign pixFrameEnd = pixValid && frameLast;

  p_hold_pix_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixData)));
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));
  p_frame_in_line_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixFrameEnd |-> pixLineEnd);
endmodule

// File: tb/test_pixel_frame_fetcher.sv
module test_pixel_frame_fetcher;
  localparam int H = 8;
  localparam int V = 4;
  localparam int S = 2;
  localparam int OUT_W = H * S;
  localparam int OUT_H = V * S;
  localparam int PIX_PER_FRAME = OUT_W * OUT_H;
  localparam logic [31:0] STAT_XY = {8'd3, 8'd2, 8'h00, 4'd2, 4'd0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] rdA, rdB;

  logic        reqA, gntA = 1'b1, rspVA = 1'b0, pixVA, readyA = 1'b1, leA, feA;
  logic [31:0] addrA;
  logic [15:0] rspDA = 16'd0;
  logic [29:0] dataA;

  logic        reqB, gntB, rspVB = 1'b0, pixVB, readyB, leB, feB;
  logic [31:0] addrB;
  logic [15:0] rspDB = 16'd0;
  logic [29:0] dataB;
  assign gntB = 1'b1;
  assign readyB = 1'b1;

  logic        stallOn = 1'b0, forceEn = 1'b0, done = 1'b0;
  logic [15:0] forceVal = 16'd0;
  int cyc = 0;
  int nChk = 0, nFail = 0;

  pixel_frame_fetcher #(.H_RES(H), .V_RES(V), .SCALE(S), .CONSEC(1'b0)) i_pixel_frame_fetcher (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rdA), .memReq(reqA), .memAddr(addrA), .memGnt(gntA),
    .memRspValid(rspVA), .memRspData(rspDA), .pixValid(pixVA), .pixReady(readyA),
    .pixData(dataA), .pixLineEnd(leA), .pixFrameEnd(feA));

  pixel_frame_fetcher #(.H_RES(H), .V_RES(V), .SCALE(S), .CONSEC(1'b1)) i_pixel_frame_fetcher_lin (
    .clk(clk), .rstN(rstN), .regWe(1'b0), .regAddr(regAddr), .regWdata(32'd0),
    .regRdata(rdB), .memReq(reqB), .memAddr(addrB), .memGnt(gntB),
    .memRspValid(rspVB), .memRspData(rspDB), .pixValid(pixVB), .pixReady(readyB),
    .pixData(dataB), .pixLineEnd(leB), .pixFrameEnd(feB));

  function automatic logic [15:0] memFun(input logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  function automatic logic [29:0] widen(input logic [15:0] d);
    return {d[15:11], d[15:11], d[10:5], d[10:7], d[4:0], d[4:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory models: one response per granted request, one cycle later
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    rspVA  <= rstN && reqA && gntA;
    rspDA  <= forceEn ? forceVal : memFun(addrA);
    rspVB  <= rstN && reqB && gntB;
    rspDB  <= memFun(addrB);
    gntA   <= !(stallOn && (cyc % 4 == 2));
    readyA <= !(stallOn && (cyc % 3 == 1));
  end

  // reference model and stream monitor for the coordinate-mode instance
  logic [31:0] mFront = 0, mBack = 0;
  bit          mPending = 0;
  int fX = 0, fLine = 0, outIdx = 0, frameCnt = 0, holdSeen = 0;
  bit reqWaitPrev = 0, pixWaitPrev = 0;
  logic [31:0] addrPrev = 0;
  logic [29:0] dataPrev = 0;
  logic [15:0] lastRsp = 0;
  int bX = 0, bLine = 0;

  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] expAddr;
      bit isEnd;
      if (reqWaitPrev) begin
        holdSeen++;
        check(reqA && addrA == addrPrev, "R11", "request held", addrA, addrPrev);
      end
      if (pixWaitPrev) begin
        holdSeen++;
        check(pixVA && dataA == dataPrev, "R10", "pixel held", 32'(dataA), 32'(dataPrev));
      end
      reqWaitPrev = reqA && !gntA;
      addrPrev    = addrA;
      pixWaitPrev = pixVA && !readyA;
      dataPrev    = dataA;

      if (reqA && gntA) begin
        expAddr = mFront + ((((fLine / S) << 3) | fX) << 1);
        check(addrA == expAddr, "R6", "coordinate address", addrA, expAddr);
        fX++;
        if (fX == H) begin
          fX = 0;
          fLine = (fLine + 1) % OUT_H;
        end
      end
      if (rspVA) lastRsp = rspDA;

      isEnd = 0;
      if (pixVA && readyA) begin
        check(dataA == widen(lastRsp), "R9", "widened colour", 32'(dataA), 32'(widen(lastRsp)));
        check(leA == (outIdx % OUT_W == OUT_W - 1), "R10", "line end flag", 32'(leA),
              32'(outIdx % OUT_W == OUT_W - 1));
        check(feA == (outIdx == PIX_PER_FRAME - 1), "R8", "frame end flag", 32'(feA),
              32'(outIdx == PIX_PER_FRAME - 1));
        isEnd = (outIdx == PIX_PER_FRAME - 1);
        outIdx = (outIdx + 1) % PIX_PER_FRAME;
      end

      if (regWe && regAddr == 2'd0) mPending = 1;
      if (regWe && regAddr == 2'd1) mBack = regWdata;
      if (isEnd) begin
        if (mPending) begin
          logic [31:0] t;
          t = mFront; mFront = mBack; mBack = t; mPending = 0;
        end
        frameCnt++;
      end

      if (reqB && gntB) begin
        expAddr = (((bLine / S) * H + bX) << 1);
        check(addrB == expAddr, "R7", "linear address", addrB, expAddr);
        bX++;
        if (bX == H) begin
          bX = 0;
          bLine = (bLine + 1) % OUT_H;
        end
      end
    end
  end

  task automatic regWr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #2;
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #2;
    regAddr = a;
    @(negedge clk);
    v = rdA;
  endtask

  task automatic waitFrame();
    int f0 = frameCnt;
    int n = 0;
    while (frameCnt == f0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(frameCnt != f0, "R8", "frame completes", 32'(frameCnt), 32'(f0 + 1));
  endtask

  task automatic tReset();
    logic [31:0] v;
    check(reqA == 1'b1 && addrA == 32'd0, "R1", "first request at 0", addrA, 32'd0);
    regRd(2'd0, v); check(v == 32'd0, "R1", "front after reset", v, 32'd0);
    regRd(2'd1, v); check(v == 32'd0, "R1", "back after reset", v, 32'd0);
    regRd(2'd3, v); check(v == STAT_XY, "R5", "status coordinate mode", v, STAT_XY);
    check(v[0] == 1'b0, "R1", "pending clear after reset", 32'(v[0]), 32'd0);
    check(rdB == (STAT_XY | 32'h2), "R5", "status linear mode", rdB, STAT_XY | 32'h2);
    regRd(2'd2, v); check(v == 32'h0004_0008, "R4", "resolution", v, 32'h0004_0008);
  endtask

  task automatic tBackAndRequest();
    logic [31:0] v;
    regWr(2'd1, 32'h0000_1000);
    regRd(2'd1, v); check(v == 32'h1000, "R2", "back readback", v, 32'h1000);
    regWr(2'd0, 32'hDEAD_BEEF);
    regRd(2'd0, v); check(v == 32'd0, "R2", "front unchanged by write", v, 32'd0);
    regRd(2'd3, v); check(v == (STAT_XY | 1), "R3", "pending set", v, STAT_XY | 1);
  endtask

  task automatic tSwap();
    logic [31:0] v;
    waitFrame();
    regRd(2'd0, v); check(v == 32'h1000, "R3", "front after exchange", v, 32'h1000);
    regRd(2'd1, v); check(v == 32'd0, "R3", "back after exchange", v, 32'd0);
    regRd(2'd3, v); check(v == STAT_XY, "R3", "pending cleared", v, STAT_XY);
  endtask

  task automatic tDoubleRequest();
    logic [31:0] v;
    regWr(2'd0, 32'd1);
    regWr(2'd0, 32'd2);
    regRd(2'd3, v); check(v[0] == 1'b1, "R3", "pending after two requests", 32'(v[0]), 32'd1);
    waitFrame();
    regRd(2'd0, v); check(v == 32'd0, "R3", "single exchange front", v, 32'd0);
    regRd(2'd1, v); check(v == 32'h1000, "R3", "single exchange back", v, 32'h1000);
    waitFrame();
    regRd(2'd0, v); check(v == 32'd0, "R3", "no second exchange", v, 32'd0);
  endtask

  task automatic tIgnoredWrites();
    logic [31:0] v;
    regWr(2'd2, 32'hFFFF_FFFF);
    regWr(2'd3, 32'hFFFF_FFFF);
    regRd(2'd2, v); check(v == 32'h0004_0008, "R12", "resolution untouched", v, 32'h0004_0008);
    regRd(2'd3, v); check(v == STAT_XY, "R12", "status untouched", v, STAT_XY);
    regRd(2'd0, v); check(v == 32'd0, "R12", "front untouched", v, 32'd0);
  endtask

  task automatic widenOne(input logic [15:0] src, input logic [29:0] exp);
    forceEn = 1'b1;
    forceVal = src;
    repeat (12) @(negedge clk);
    while (!pixVA) @(negedge clk);
    check(dataA == exp, "R9", "fixed colour widening", 32'(dataA), 32'(exp));
    forceEn = 1'b0;
  endtask

  task automatic tWiden();
    widenOne(16'hF800, {10'h3FF, 10'h000, 10'h000});
    widenOne(16'hF81F, {10'h3FF, 10'h000, 10'h3FF});
    widenOne(16'hFFFF, {10'h3FF, 10'h3FF, 10'h3FF});
    widenOne(16'h8410, {10'h210, 10'h208, 10'h210});
    widenOne(16'h07E0, {10'h000, 10'h3FF, 10'h000});
  endtask

  task automatic tStall();
    logic [31:0] v;
    stallOn = 1'b1;
    regWr(2'd1, 32'h0000_2000);
    regWr(2'd0, 32'd0);
    waitFrame();
    waitFrame();
    regRd(2'd0, v); check(v == 32'h2000, "R3", "exchange under stalls", v, 32'h2000);
    stallOn = 1'b0;
    check(holdSeen > 0, "R10", "stalls exercised", 32'(holdSeen), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBackAndRequest();
    tSwap();
    tDoubleRequest();
    tIgnoredWrites();
    tWiden();
    tStall();
    waitFrame();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule